// File: doc/BRIEF.md
# Tri-state PWM Gate-Drive Controller

This block is the digital heart of a synchronous buck half-bridge driver. A front-end comparator pair has already sorted the PWM pin voltage into one of three classes: low, high, or inside the hysteresis window. The block turns that class into two gate enables, one for the high-side switch and one for the low-side switch. Break-before-make dead time is inserted between them.

A controller that releases its PWM line leaves the pin floating in the mid window. If the pin stays there long enough, a hold-off timer parks both switches off. The block also comes out of reset parked. It leaves the parked state only when it sees a real high level. Three further inputs gate the outputs:

- A low-side block input keeps the low-side switch off, for discontinuous conduction.
- A driver enable turns both switches off.
- A protection flag from the supply supervisor turns both switches off at once, combinationally, without waiting for a clock edge.

Top module: `gate_drive_core`

## Requirements
- R1: The `pwm_cls` code is decoded as follows: 2'b10 means high and 2'b00 means low. With the block active, high drives `gh` on and `gl` off. Low drives `gl` on and `gh` off.
- R2: If `pwm_cls` is sampled in the mid window on HOLD_CYC consecutive rising edges, both gates go off and the block parks. Fewer consecutive mid samples do not park it.
- R3: While parked, a low code keeps both gates off. Only a high code ends the parked state.
- R4: After reset the block is parked with both gates off. It stays parked under a low code until the first high code arrives.
- R5: `gh` and `gl` are never both on in the same cycle.
- R6: When the drive direction changes, the outputs show exactly DEAD_CYC+1 cycles with both gates off before the other gate turns on. A gate turns off on the edge after its command is withdrawn.
- R7: While `ls_blk_n` is low, `gl` stays off and `gh` still follows the PWM code.
- R8: While `drv_en` is low, both gates are off from the next edge on.
- R9: While `prot_ok` is low, both gates are off in the same cycle, with no clock edge needed.
- R10: The reserved code 2'b11 behaves exactly like the mid-window code 2'b01.
- R11: A mid-window interval shorter than the hold-off time keeps the gate state that was commanded last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_cls | input | 2 | Classified PWM level: 00 low, 01 mid, 10 high, 11 mid |
| drv_en | input | 1 | Driver enable; low forces both gates off |
| ls_blk_n | input | 1 | Low-side block, active low |
| prot_ok | input | 1 | Supervisor protection-good flag |
| gh | output | 1 | High-side gate enable |
| gl | output | 1 | Low-side gate enable |

## Verification
Several of these functions can fall in the same cycle, and the bench provokes the overlaps deliberately:

- **Dead time with another event.** The dead-time wait can coincide with a mid-window excursion, with a release from the parked state, or with the low-side block. The bench moves the PWM code between classes while a dead-time interval is still counting.
- **Protection drop with a transition.** The protection flag can drop in the middle of a transition. The bench pulls `prot_ok` low between edges and samples the gates in that same cycle.

A behavioural model in the bench predicts both gates on every cycle, and the bench compares against it. Explicit checks additionally measure the width of the dead-time gap and the first high after reset.

// File: rtl/gate_drive_core.sv
module gate_drive_core #(
  parameter int HOLD_CYC = 30,
  parameter int DEAD_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_cls,
  input  logic       drv_en,
  input  logic       ls_blk_n,
  input  logic       prot_ok,
  output logic       gh,
  output logic       gl
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int DW = $clog2(DEAD_CYC + 1);

  logic          parked, cmd_hi, gh_q, gl_q;
  logic [HW-1:0] hold_cnt;
  logic [DW-1:0] gap_cnt;

  wire is_hi  = (pwm_cls == 2'b10);
  wire is_lo  = (pwm_cls == 2'b00);
  wire is_mid = pwm_cls[0];

  wire active   = ~parked & drv_en & prot_ok;
  wire want_h   = active & cmd_hi;
  wire want_l   = active & ~cmd_hi & ls_blk_n;
  wire gap_done = (gap_cnt == DW'(DEAD_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parked   <= 1'b1;
      cmd_hi   <= 1'b0;
      hold_cnt <= '0;
    end else begin
      if (is_mid) begin
        if (hold_cnt != HW'(HOLD_CYC)) hold_cnt <= hold_cnt + 1'b1;
        if (hold_cnt == HW'(HOLD_CYC - 1)) parked <= 1'b1;
      end else begin
        hold_cnt <= '0;
      end
      if (is_hi) begin
        parked <= 1'b0;
        cmd_hi <= 1'b1;
      end else if (is_lo) begin
        cmd_hi <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gh_q    <= 1'b0;
      gl_q    <= 1'b0;
      gap_cnt <= '0;
    end else begin
      gh_q <= want_h & (gh_q | (~gl_q & gap_done));
      gl_q <= want_l & (gl_q | (~gh_q & gap_done));
      if (gh_q | gl_q)   gap_cnt <= '0;
      else if (!gap_done) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assign gh = gh_q & prot_ok;
  assign gl = gl_q & prot_ok;

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n) !(gh_q && gl_q));
  a_r6_gap_before_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gh_q) |-> $past(!gl_q) && $past(!gl_q, 2));
  a_r6_gap_before_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gl_q) |-> $past(!gh_q) && $past(!gh_q, 2));
  a_r3_parked_off: assert property (@(posedge clk) disable iff (!rst_n)
    $past(parked) |-> !gh_q && !gl_q);
  a_r3_high_exits: assert property (@(posedge clk) disable iff (!rst_n)
    is_hi |=> !parked);
  a_r7_low_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ls_blk_n) |-> !gl_q);
  a_r8_disabled_off: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!drv_en) |-> !gh_q && !gl_q);
  always_comb a_r9_prot_now: assert (prot_ok || (!gh && !gl));
endmodule

// File: tb/sim_gate_drive_core.sv
module sim_gate_drive_core;
  localparam int HOLD = 30;
  localparam int DEAD = 3;

  logic clk = 0, rst_n = 0;
  logic [1:0] pwm_cls = 2'b00;
  logic drv_en = 1, ls_blk_n = 1, prot_ok = 1;
  logic gh, gl;
  int n_chk = 0, n_bad = 0;
  string cur_req = "R4";

  gate_drive_core #(.HOLD_CYC(HOLD), .DEAD_CYC(DEAD)) u0 (
    .clk(clk), .rst_n(rst_n), .pwm_cls(pwm_cls), .drv_en(drv_en),
    .ls_blk_n(ls_blk_n), .prot_ok(prot_ok), .gh(gh), .gl(gl));

  always #2.5 clk = ~clk;

  // behavioural reference
  bit m_park = 1, m_dir = 0, m_h = 0, m_l = 0;
  int m_run = 0, m_off = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_park = 1; m_dir = 0; m_h = 0; m_l = 0; m_run = 0; m_off = 0;
    end else begin
      bit on, nh, nl;
      on = !m_park && drv_en && prot_ok;
      nh = on && m_dir && (m_h || (!m_l && m_off >= DEAD));
      nl = on && !m_dir && ls_blk_n && (m_l || (!m_h && m_off >= DEAD));
      m_off = (m_h || m_l) ? 0 : m_off + 1;
      m_h = nh; m_l = nl;
      if (pwm_cls == 2'b01 || pwm_cls == 2'b11) begin
        m_run++;
        if (m_run == HOLD) m_park = 1;
      end else m_run = 0;
      if (pwm_cls == 2'b10) begin m_park = 0; m_dir = 1; end
      if (pwm_cls == 2'b00) m_dir = 0;
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] c);
    @(negedge clk);
    pwm_cls = c;
    #1;
    check(cur_req, gh, m_h && prot_ok, "gh");
    check(cur_req, gl, m_l && prot_ok, "gl");
    check("R5", gh && gl, 1'b0, "overlap");
  endtask

  task automatic hold(input logic [1:0] c, input int n);
    for (int i = 0; i < n; i++) step(c);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    int gap;
    #12; @(negedge clk); rst_n = 1;
    #1 check("R4", gh | gl, 1'b0, "reset gates");
    cur_req = "R4"; hold(2'b00, 12);
    check("R4", gl, 1'b0, "parked under low");
    cur_req = "R1"; hold(2'b10, 8);
    check("R1", gh, 1'b1, "first high drives gh");
    // measure dead gap high->low
    cur_req = "R6"; step(2'b00);
    gap = 0;
    for (int i = 0; i < 20; i++) begin
      step(2'b00);
      if (!gh && !gl) gap++;
      if (gl) break;
    end
    check("R6", gap == DEAD + 1, 1'b1, "dead gap width");
    cur_req = "R1";
    for (int k = 0; k < 4; k++) begin hold(2'b10, 3 + k); hold(2'b00, 7 - k); end
    cur_req = "R11"; hold(2'b00, 8); hold(2'b01, HOLD - 2); hold(2'b00, 2);
    check("R11", gl, 1'b1, "short mid keeps low side");
    hold(2'b10, 8); hold(2'b11, HOLD - 1); check("R11", gh, 1'b1, "short mid keeps high side");
    cur_req = "R2"; hold(2'b01, 4);
    check("R2", gh | gl, 1'b0, "parked after hold-off");
    cur_req = "R3"; hold(2'b00, 10);
    check("R3", gl, 1'b0, "low does not leave park");
    hold(2'b10, 8); check("R3", gh, 1'b1, "high leaves park");
    cur_req = "R10"; hold(2'b11, HOLD + 3);
    check("R10", gh, 1'b0, "code 11 parks");
    cur_req = "R7"; hold(2'b10, 6); ls_blk_n = 0;
    for (int k = 0; k < 3; k++) begin hold(2'b00, 6); hold(2'b10, 6); end
    check("R7", gh, 1'b1, "gh follows with low side blocked");
    hold(2'b00, 6); check("R7", gl, 1'b0, "gl held off");
    ls_blk_n = 1; hold(2'b00, 8);
    cur_req = "R8"; drv_en = 0; hold(2'b10, 6); hold(2'b00, 4);
    check("R8", gh | gl, 1'b0, "disabled");
    drv_en = 1; hold(2'b10, 8);
    cur_req = "R9";
    @(negedge clk); prot_ok = 0; #1;
    check("R9", gh, 1'b0, "protection immediate");
    hold(2'b10, 3); prot_ok = 1; hold(2'b10, 8); hold(2'b00, 2);
    @(negedge clk); prot_ok = 0; #1; check("R9", gl | gh, 1'b0, "protection mid transition");
    hold(2'b00, 3); prot_ok = 1; hold(2'b00, 8);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule